// File: doc/BRIEF.md
# Configurable PCM Frame Serializer

This block produces the frame timing of a two-channel serial audio link and sends one stereo sample pair per frame on a single data line. It runs in the system clock domain. Two single-cycle strobes mark the bit-clock edges, and a configuration bit picks which of them launches data. At every launch the block advances a bit-position counter that wraps at a programmable frame length. From that position it derives a frame sync output of programmable length and polarity, and it drives the bit that belongs to the current position.

Each channel has its own start position, its own enable and a shared width. With these a single engine can produce I2S, left-justified, right-justified, DSP-A and DSP-B framing. The block can also act as a frame sync consumer. In that mode it realigns its counter to the frame start edge on an external sync input instead of producing sync itself. At each frame start the block requests a fresh sample pair with a one-cycle handshake. If no pair is offered, it sends silence and records the miss.

Top module: `pcm_frame_serializer`

## Requirements
- R1: The frame is `cfg_frame_last + 1` launch edges long. The position counter runs 0 to `cfg_frame_last` and then returns to 0.
- R2: Frame sync is active while the position is below `cfg_sync_len`. A value of 0 keeps it inactive for the whole frame.
- R3: When `cfg_fs_inv` is 0, sync is active high and a frame begins on its rising transition. When it is 1, `fs_out` is inverted and a frame begins on the falling transition.
- R4: Data is sent MSB first, and samples are right-aligned in their 32-bit inputs. At position `start + k`, a channel of width W drives sample bit `W-1-k`. Sample bits above W are ignored.
- R5: The channel width in bits is `8 + cfg_wid + 16*cfg_wext`. Any result above 32 is treated as 32.
- R6: At positions outside both channel windows the data line is 0. Where the two windows overlap, the left channel (channel 0) wins.
- R7: A channel whose enable bit is 0 drives 0 for its entire window.
- R8: `smp_ready` is high for exactly one clock, on the launch edge that begins a frame (position 0). The pair on `smp_left`/`smp_right` is taken in that clock if `smp_valid` is high. A channel that starts at position 0 sends the new pair at once.
- R9: If `smp_valid` is low when `smp_ready` is high, the whole frame sends zeros and `underrun` is set. `underrun` stays set until reset.
- R10: When `cfg_clk_inv` is 0, `bit_fall` launches data and `bit_rise` has no effect. When it is 1, `bit_rise` launches and `bit_fall` has no effect. Outputs change only on a launch.
- R11: When `cfg_fs_consumer` is 1, `fs_out` is held at 0. A launch that sees the frame start transition on `fs_in` (as defined in R3) becomes position 0. Otherwise the counter keeps wrapping as in R1.
- R12: After reset `fs_out`, `sd_out`, `underrun` and `smp_ready` are 0, and the first launch is position 0 of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_rise | input | 1 | One-cycle strobe at a bit-clock rising edge |
| bit_fall | input | 1 | One-cycle strobe at a bit-clock falling edge |
| cfg_frame_last | input | 10 | Frame length minus one, in bit clocks |
| cfg_sync_len | input | 10 | Number of bit clocks that frame sync stays active |
| cfg_ch0_start | input | 10 | First bit position of the left channel |
| cfg_ch1_start | input | 10 | First bit position of the right channel |
| cfg_wid | input | 4 | Width field (width minus 8, low part) |
| cfg_wext | input | 1 | Width extension, adds 16 bits |
| cfg_ch0_en | input | 1 | Left channel enable |
| cfg_ch1_en | input | 1 | Right channel enable |
| cfg_fs_inv | input | 1 | Frame starts on the falling sync transition |
| cfg_clk_inv | input | 1 | Launch on the rising bit-clock strobe |
| cfg_fs_consumer | input | 1 | Follow external frame sync |
| fs_in | input | 1 | External frame sync |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Sample pair taken this clock |
| smp_left | input | 32 | Left sample, right-aligned |
| smp_right | input | 32 | Right sample, right-aligned |
| fs_out | output | 1 | Frame sync output |
| sd_out | output | 1 | Serial data output |
| underrun | output | 1 | Sticky missed-sample flag |

## Verification
Two functions can fall in the same launch. The first case is the frame-start sample hand-over together with the first data bit, when a channel starts at position 0. The second case is an external sync edge together with the counter's natural wrap, or in the middle of a frame. DSP-B framing with the left channel at position 0 is used to provoke the first case. The bit on `sd_out` after that launch must already be the MSB of the pair offered in that same clock, not of the previous pair. In consumer mode the bench raises `fs_in` at a position in mid-frame. It expects position 0, a `smp_ready` pulse and the new MSB on that launch, compared against its own position model.

// File: rtl/pcm_ser_pkg.sv
// Package: shared constants and types of the PCM frame serializer.
// Assumes: channel width decoding is base plus field plus an extension step.
package pcm_ser_pkg;
    localparam int unsigned BASE_WIDTH = 8;
    localparam int unsigned EXT_STEP   = 16;

    // Source that drives the data line at a given bit position.
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_LEFT  = 2'd1,
        SRC_RIGHT = 2'd2
    } slot_src_e;
endpackage

// File: rtl/pcm_ser_counter.sv
// Module: bit-position counter of the frame.
// Does: advances on every launch, wraps at the programmed last position, and
// in consumer mode realigns to the frame start transition on the sync input.
// Assumes: step is a single-cycle strobe; config is stable while in use.
module pcm_ser_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] frame_last,
    input  logic             consumer,
    input  logic             fs_inv,
    input  logic             fs_in,
    output logic [CNT_W-1:0] next_pos,
    output logic             frame_start
);
    logic [CNT_W-1:0] pos_q;
    logic             started_q;
    logic             prev_act_q;
    logic             act_lvl;
    logic             fs_edge;

    // Active level of the external sync and detection of its start transition.
    always_comb begin
        act_lvl = fs_in ^ fs_inv;
        fs_edge = act_lvl & ~prev_act_q;
    end

    // Position that the next launch moves to.
    always_comb begin
        if (!started_q)
            next_pos = '0;
        else if (consumer && fs_edge)
            next_pos = '0;
        else if (pos_q == frame_last)
            next_pos = '0;
        else
            next_pos = pos_q + CNT_W'(1);
        frame_start = step && (next_pos == '0);
    end

    // Position, start flag and previous sync level, updated on a launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q      <= '0;
            started_q  <= 1'b0;
            prev_act_q <= 1'b0;
        end else if (step) begin
            pos_q      <= next_pos;
            started_q  <= 1'b1;
            prev_act_q <= act_lvl;
        end
    end
endmodule

// File: rtl/pcm_ser_sample.sv
// Module: sample pair hand-over and underrun tracking.
// Does: takes a left/right pair at each frame start, substitutes zeros when
// none is offered and sets a sticky underrun flag.
// Assumes: frame_start is a single-cycle strobe.
module pcm_ser_sample #(
    parameter int SMP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_left,
    input  logic [SMP_W-1:0] smp_right,
    output logic             smp_ready,
    output logic [SMP_W-1:0] cur_left,
    output logic [SMP_W-1:0] cur_right,
    output logic             underrun
);
    logic [SMP_W-1:0] held_left_q;
    logic [SMP_W-1:0] held_right_q;
    logic             under_q;

    // Pair in force at this launch: fresh at a frame start, held otherwise.
    always_comb begin
        smp_ready = frame_start;
        if (frame_start) begin
            cur_left  = smp_valid ? smp_left  : '0;
            cur_right = smp_valid ? smp_right : '0;
        end else begin
            cur_left  = held_left_q;
            cur_right = held_right_q;
        end
        underrun = under_q;
    end

    // Hold the pair for the frame and latch a missed hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_left_q  <= '0;
            held_right_q <= '0;
            under_q      <= 1'b0;
        end else if (frame_start) begin
            held_left_q  <= cur_left;
            held_right_q <= cur_right;
            if (!smp_valid)
                under_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pcm_ser_slot.sv
// Module: channel window decode and bit select.
// Does: for each channel checks whether a position lies in its window and
// picks the MSB-first bit; the left channel wins an overlap.
// Assumes: samples are right-aligned; widths above SMP_W are clamped.
module pcm_ser_slot
    import pcm_ser_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int SMP_W = 32,
    parameter int WID_W = 4
) (
    input  logic [CNT_W-1:0]            pos,
    input  logic [WID_W-1:0]            wid,
    input  logic                        wext,
    input  logic [1:0][CNT_W-1:0]       ch_start,
    input  logic [1:0]                  ch_en,
    input  logic [1:0][SMP_W-1:0]       ch_data,
    output logic                        bit_out
);
    localparam int SPAN_W = CNT_W + 1;
    localparam int IDX_W  = $clog2(SMP_W);

    logic [SPAN_W-1:0] raw_w;
    logic [SPAN_W-1:0] eff_w;
    logic [1:0]        hit;
    logic [1:0]        bit_v;
    slot_src_e         src;

    // Channel width from the field and extension, clamped to the sample size.
    always_comb begin
        raw_w = SPAN_W'(BASE_WIDTH) + SPAN_W'(wid) + (wext ? SPAN_W'(EXT_STEP) : '0);
        eff_w = (raw_w > SPAN_W'(SMP_W)) ? SPAN_W'(SMP_W) : raw_w;
    end

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        logic [SPAN_W-1:0] off;
        logic [IDX_W-1:0]  idx;
        // Window membership and MSB-first bit index of this channel.
        always_comb begin
            off       = {1'b0, pos} - {1'b0, ch_start[ch]};
            hit[ch]   = ch_en[ch] && (pos >= ch_start[ch]) && (off < eff_w);
            idx       = IDX_W'(eff_w - SPAN_W'(1) - off);
            bit_v[ch] = ch_data[ch][idx];
        end
    end

    // Priority pick of the source that drives this position.
    always_comb begin
        if (hit[0])      src = SRC_LEFT;
        else if (hit[1]) src = SRC_RIGHT;
        else             src = SRC_NONE;
        case (src)
            SRC_LEFT:  bit_out = bit_v[0];
            SRC_RIGHT: bit_out = bit_v[1];
            default:   bit_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcm_frame_serializer.sv
// Module: top of the PCM frame serializer.
// Does: selects the launch strobe, runs the position counter, generates frame
// sync and registers the serial data bit for each position.
// Assumes: bit strobes are single-cycle pulses in the clk domain.
module pcm_frame_serializer #(
    parameter int CNT_W = 10,
    parameter int SMP_W = 32,
    parameter int WID_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_rise,
    input  logic             bit_fall,
    input  logic [CNT_W-1:0] cfg_frame_last,
    input  logic [CNT_W-1:0] cfg_sync_len,
    input  logic [CNT_W-1:0] cfg_ch0_start,
    input  logic [CNT_W-1:0] cfg_ch1_start,
    input  logic [WID_W-1:0] cfg_wid,
    input  logic             cfg_wext,
    input  logic             cfg_ch0_en,
    input  logic             cfg_ch1_en,
    input  logic             cfg_fs_inv,
    input  logic             cfg_clk_inv,
    input  logic             cfg_fs_consumer,
    input  logic             fs_in,
    input  logic             smp_valid,
    output logic             smp_ready,
    input  logic [SMP_W-1:0] smp_left,
    input  logic [SMP_W-1:0] smp_right,
    output logic             fs_out,
    output logic             sd_out,
    output logic             underrun
);
    logic             step;
    logic [CNT_W-1:0] next_pos;
    logic             frame_start;
    logic [SMP_W-1:0] cur_left;
    logic [SMP_W-1:0] cur_right;
    logic             data_bit;
    logic             fs_nxt;
    logic             fs_q;
    logic             sd_q;

    // Launch strobe chosen by the clock-invert setting.
    always_comb step = cfg_clk_inv ? bit_rise : bit_fall;

    pcm_ser_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (step),
        .frame_last  (cfg_frame_last),
        .consumer    (cfg_fs_consumer),
        .fs_inv      (cfg_fs_inv),
        .fs_in       (fs_in),
        .next_pos    (next_pos),
        .frame_start (frame_start)
    );

    pcm_ser_sample #(.SMP_W(SMP_W)) u_smp (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .smp_valid   (smp_valid),
        .smp_left    (smp_left),
        .smp_right   (smp_right),
        .smp_ready   (smp_ready),
        .cur_left    (cur_left),
        .cur_right   (cur_right),
        .underrun    (underrun)
    );

    pcm_ser_slot #(.CNT_W(CNT_W), .SMP_W(SMP_W), .WID_W(WID_W)) u_slot (
        .pos      (next_pos),
        .wid      (cfg_wid),
        .wext     (cfg_wext),
        .ch_start ({cfg_ch1_start, cfg_ch0_start}),
        .ch_en    ({cfg_ch1_en, cfg_ch0_en}),
        .ch_data  ({cur_right, cur_left}),
        .bit_out  (data_bit)
    );

    // Frame sync level for the next position; silent when following outside sync.
    always_comb begin
        if (cfg_fs_consumer)
            fs_nxt = 1'b0;
        else
            fs_nxt = (next_pos < cfg_sync_len) ^ cfg_fs_inv;
    end

    // Output registers, updated only on a launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q <= 1'b0;
            sd_q <= 1'b0;
        end else if (step) begin
            fs_q <= fs_nxt;
            sd_q <= data_bit;
        end
    end

    always_comb begin
        fs_out = fs_q;
        sd_out = sd_q;
    end
endmodule

// File: rtl/pcm_ser_chk.sv
// Module: property checker for the PCM frame serializer, bound to its top.
// Assumes: only top-level ports are observed.
module pcm_ser_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_rise,
    input logic             bit_fall,
    input logic             cfg_clk_inv,
    input logic             cfg_ch0_en,
    input logic             cfg_ch1_en,
    input logic             cfg_fs_consumer,
    input logic             cfg_fs_inv,
    input logic [CNT_W-1:0] cfg_sync_len,
    input logic             smp_valid,
    input logic             smp_ready,
    input logic             fs_out,
    input logic             sd_out,
    input logic             underrun
);
    logic launch;

    // Launch strobe as the spec defines it.
    always_comb launch = cfg_clk_inv ? bit_rise : bit_fall;

    // R10
    hold_between_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> ($stable(sd_out) && $stable(fs_out)));

    // R7
    both_muted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !cfg_ch0_en && !cfg_ch1_en) |=> !sd_out);

    // R9
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    // R9
    underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_ready && !smp_valid) |=> underrun);

    // R8
    ready_on_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> launch);

    // R11
    consumer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && cfg_fs_consumer) |=> !fs_out);

    // R2
    zero_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !cfg_fs_consumer && !cfg_fs_inv && cfg_sync_len == '0) |=> !fs_out);
endmodule

bind pcm_frame_serializer pcm_ser_chk #(.CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bit_rise        (bit_rise),
    .bit_fall        (bit_fall),
    .cfg_clk_inv     (cfg_clk_inv),
    .cfg_ch0_en      (cfg_ch0_en),
    .cfg_ch1_en      (cfg_ch1_en),
    .cfg_fs_consumer (cfg_fs_consumer),
    .cfg_fs_inv      (cfg_fs_inv),
    .cfg_sync_len    (cfg_sync_len),
    .smp_valid       (smp_valid),
    .smp_ready       (smp_ready),
    .fs_out          (fs_out),
    .sd_out          (sd_out),
    .underrun        (underrun)
);

// File: tb/pcm_frame_serializer_test.sv
// Directed bench: each task sets up one framing scenario and checks every
// launch against a position model built from the requirements.
module pcm_frame_serializer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_rise = 1'b0, bit_fall = 1'b0;
    logic [9:0]  cfg_frame_last = '0, cfg_sync_len = '0;
    logic [9:0]  cfg_ch0_start = '0, cfg_ch1_start = '0;
    logic [3:0]  cfg_wid = '0;
    logic        cfg_wext = 1'b0, cfg_ch0_en = 1'b0, cfg_ch1_en = 1'b0;
    logic        cfg_fs_inv = 1'b0, cfg_clk_inv = 1'b0, cfg_fs_consumer = 1'b0;
    logic        fs_in = 1'b0, smp_valid = 1'b0;
    logic        smp_ready, fs_out, sd_out, underrun;
    logic [31:0] smp_left = '0, smp_right = '0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // model state
    int          m_pos;
    bit          m_started, m_prev, m_under;
    logic [31:0] m_left, m_right;

    always #2 clk = ~clk;

    pcm_frame_serializer uut (
        .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .bit_fall(bit_fall),
        .cfg_frame_last(cfg_frame_last), .cfg_sync_len(cfg_sync_len),
        .cfg_ch0_start(cfg_ch0_start), .cfg_ch1_start(cfg_ch1_start),
        .cfg_wid(cfg_wid), .cfg_wext(cfg_wext), .cfg_ch0_en(cfg_ch0_en),
        .cfg_ch1_en(cfg_ch1_en), .cfg_fs_inv(cfg_fs_inv), .cfg_clk_inv(cfg_clk_inv),
        .cfg_fs_consumer(cfg_fs_consumer), .fs_in(fs_in), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .smp_left(smp_left), .smp_right(smp_right),
        .fs_out(fs_out), .sd_out(sd_out), .underrun(underrun)
    );

    task automatic check(input string tag, input logic act, input logic exp, input int pos);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s pos=%0d actual=%0b expected=%0b", tag, pos, act, exp);
        end
    endtask

    function automatic logic model_sd(input int p);
        int w;
        w = 8 + int'(cfg_wid) + (cfg_wext ? 16 : 0);
        if (w > 32) w = 32;
        if (cfg_ch0_en && p >= int'(cfg_ch0_start) && p < int'(cfg_ch0_start) + w)
            return m_left[w - 1 - (p - int'(cfg_ch0_start))];
        if (cfg_ch1_en && p >= int'(cfg_ch1_start) && p < int'(cfg_ch1_start) + w)
            return m_right[w - 1 - (p - int'(cfg_ch1_start))];
        return 1'b0;
    endfunction

    function automatic logic model_fs(input int p);
        if (cfg_fs_consumer) return 1'b0;
        return logic'(p < int'(cfg_sync_len)) ^ cfg_fs_inv;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_rise = 1'b0; bit_fall = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_pos = 0; m_started = 1'b0; m_prev = 1'b0; m_under = 1'b0;
        m_left = '0; m_right = '0;
    endtask

    // One launch on the configured edge, checked against the model.
    task automatic do_step(input string sd_tag, input string fs_tag);
        bit act, fedge, fstart;
        int np;
        @(negedge clk);
        if (cfg_clk_inv) bit_rise = 1'b1; else bit_fall = 1'b1;
        #1;
        act   = fs_in ^ cfg_fs_inv;
        fedge = act && !m_prev;
        if (!m_started) np = 0;
        else if (cfg_fs_consumer && fedge) np = 0;
        else if (m_pos == int'(cfg_frame_last)) np = 0;
        else np = m_pos + 1;
        m_prev = act; m_started = 1'b1; m_pos = np;
        fstart = (np == 0);
        check("R8", smp_ready, fstart, np);
        if (fstart) begin
            if (smp_valid) begin m_left = smp_left; m_right = smp_right; end
            else begin m_left = '0; m_right = '0; m_under = 1'b1; end
        end
        @(negedge clk);
        bit_rise = 1'b0; bit_fall = 1'b0;
        check(sd_tag, sd_out, model_sd(np), np);
        check(fs_tag, fs_out, model_fs(np), np);
        check("R9", underrun, m_under, np);
    endtask

    task automatic run(input int n, input string sd_tag, input string fs_tag);
        for (int i = 0; i < n; i++) do_step(sd_tag, fs_tag);
    endtask

    task automatic base_cfg();
        cfg_fs_inv = 0; cfg_clk_inv = 0; cfg_fs_consumer = 0; fs_in = 0;
        cfg_ch0_en = 1; cfg_ch1_en = 1; cfg_wext = 0;
        smp_valid = 1; smp_left = 32'hA5C3_9E71; smp_right = 32'h3C0F_5AA6;
    endtask

    task automatic t_reset();
        base_cfg();
        do_reset();
        @(negedge clk);
        check("R12", fs_out, 1'b0, -1);
        check("R12", sd_out, 1'b0, -1);
        check("R12", underrun, 1'b0, -1);
        check("R12", smp_ready, 1'b0, -1);
        do_step("R12", "R12");
    endtask

    task automatic t_i2s();
        base_cfg();
        cfg_frame_last = 63; cfg_sync_len = 32; cfg_wid = 8;
        cfg_ch0_start = 1; cfg_ch1_start = 33;
        do_reset();
        run(64, "R4", "R1");
        smp_left = 32'h0000_8001; smp_right = 32'h0000_7FFE;
        run(64, "R4", "R1");
    endtask

    task automatic t_dsp_b();
        base_cfg();
        cfg_frame_last = 47; cfg_sync_len = 1; cfg_wid = 0; cfg_wext = 1;
        cfg_ch0_start = 0; cfg_ch1_start = 24;
        do_reset();
        run(48, "R5", "R2");
        smp_left = 32'h00F0_0F0F; smp_right = 32'h0081_2244;
        run(48, "R8", "R2");
    endtask

    task automatic t_wide();
        base_cfg();
        cfg_frame_last = 69; cfg_sync_len = 0; cfg_wid = 8; cfg_wext = 1;
        cfg_ch0_start = 0; cfg_ch1_start = 35;
        do_reset();
        run(70, "R5", "R2");
        cfg_wid = 15;
        run(70, "R5", "R6");
    endtask

    task automatic t_fs_inv();
        base_cfg();
        cfg_fs_inv = 1;
        cfg_frame_last = 39; cfg_sync_len = 20; cfg_wid = 4;
        cfg_ch0_start = 0; cfg_ch1_start = 20;
        do_reset();
        run(80, "R4", "R3");
    endtask

    task automatic t_overlap_mute();
        base_cfg();
        cfg_frame_last = 39; cfg_sync_len = 1; cfg_wid = 8;
        cfg_ch0_start = 0; cfg_ch1_start = 8;
        do_reset();
        run(40, "R6", "R2");
        cfg_ch1_en = 0;
        run(40, "R7", "R2");
        cfg_ch1_en = 1; cfg_ch0_en = 0;
        run(40, "R7", "R2");
    endtask

    task automatic t_underrun();
        base_cfg();
        cfg_frame_last = 31; cfg_sync_len = 16; cfg_wid = 8;
        cfg_ch0_start = 0; cfg_ch1_start = 16;
        do_reset();
        run(32, "R9", "R2");
        smp_valid = 0;
        run(32, "R9", "R2");
        smp_valid = 1; smp_left = 32'h0000_FFFF; smp_right = 32'h0000_C3C3;
        run(32, "R9", "R2");
    endtask

    task automatic t_clk_edge();
        logic sd_b, fs_b;
        base_cfg();
        cfg_frame_last = 31; cfg_sync_len = 16; cfg_wid = 8;
        cfg_ch0_start = 1; cfg_ch1_start = 17;
        do_reset();
        run(5, "R10", "R10");
        for (int i = 0; i < 6; i++) begin
            sd_b = sd_out; fs_b = fs_out;
            @(negedge clk); bit_rise = 1'b1; #1;
            check("R10", smp_ready, 1'b0, m_pos);
            @(negedge clk); bit_rise = 1'b0;
            check("R10", sd_out, sd_b, m_pos);
            check("R10", fs_out, fs_b, m_pos);
        end
        run(40, "R10", "R10");
        cfg_clk_inv = 1;
        do_reset();
        run(64, "R10", "R10");
    endtask

    task automatic t_consumer();
        base_cfg();
        cfg_fs_consumer = 1;
        cfg_frame_last = 31; cfg_sync_len = 16; cfg_wid = 8;
        cfg_ch0_start = 0; cfg_ch1_start = 16;
        do_reset();
        run(10, "R11", "R11");
        smp_left = 32'h0000_9A9A; fs_in = 1;
        run(12, "R11", "R11");
        fs_in = 0;
        run(20, "R11", "R11");
        fs_in = 1; smp_left = 32'h0000_F00D;
        run(40, "R11", "R11");
    endtask

    initial begin
        t_reset();
        t_i2s();
        t_dsp_b();
        t_wide();
        t_fs_inv();
        t_overlap_mute();
        t_underrun();
        t_clk_edge();
        t_consumer();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog run did not complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule